// File: doc/BRIEF.md
# Branch Target Buffer with Next-PC Select

This block keeps a direct-mapped table of branch and jump targets, indexed by the fetch address. In the fetch stage it takes the current PC and the taken bit from a separate direction predictor. In the same cycle, with no clock edge in the path, it looks up the entry, decides whether fetch should redirect, and drives the next fetch address.

The final taken decision is the direction bit ORed with an unconditional-jump flag held in the entry. Both count only when the entry is valid and its tag matches the fetch PC. In every other case fetch continues at PC+4.

The execute stage fills the table through a single write port, once a branch or jump has resolved. That write either installs a new entry or refreshes an existing one. The block also outputs the predicted-taken bit and the chosen target, so the pipeline can carry them to the execute stage and compare them there.

Top module: `btb_fetch_sel`

## Requirements
- R1: Reset clears every entry's valid flag, so every lookup misses until an entry is written. After reset, `lookupHit` and `predTaken` are 0 and `nextPc` is `fetchPc`+4, whatever `dirTaken` is.
- R2: The entry index is `fetchPc[OFS_W+IDX_W-1:OFS_W]`, which is bits [7:2] by default. The tag is `fetchPc[PC_W-1:OFS_W+IDX_W]`, which is bits [31:8] by default. A hit needs the indexed entry to be valid and its stored tag to equal the fetch tag. This also holds for the highest index (63).
- R3: On a hit, if `dirTaken` is 1 or the entry's jump flag is 1, then `predTaken` is 1 and `nextPc` is the stored target.
- R4: On a hit where both `dirTaken` and the jump flag are 0, `predTaken` is 0 and `nextPc` is `fetchPc`+4.
- R5: On a miss, including a tag mismatch at an occupied index, `predTaken` is 0 and `nextPc` is `fetchPc`+4, even when `dirTaken` is 1.
- R6: A clock edge with `wrEn` high stores, at the index of `wrPc`, the valid flag, the tag of `wrPc`, `wrTarget` and `wrIsJump`. This replaces any older entry at that index, whatever its tag was.
- R7: When a lookup and a write hit the same index in one cycle, the lookup sees the entry as it was before the write. The new contents are visible from the next cycle.
- R8: `predTarget` is the stored target on a hit and `fetchPc`+4 on a miss. It does not depend on the taken decision.
- R9: The PC+4 fall-through wraps modulo 2^PC_W, so a fetch at 0xFFFFFFFC falls through to 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchPc | input | PC_W | PC being fetched |
| dirTaken | input | 1 | Taken bit from the direction predictor |
| wrEn | input | 1 | Install or refresh an entry from the execute stage |
| wrPc | input | PC_W | PC of the resolved branch or jump |
| wrTarget | input | PC_W | Resolved target address |
| wrIsJump | input | 1 | Resolved instruction is an unconditional jump |
| nextPc | output | PC_W | Next fetch address |
| predTaken | output | 1 | Final taken prediction |
| predTarget | output | PC_W | Chosen target (stored target on a hit, else PC+4) |
| lookupHit | output | 1 | Valid entry with a matching tag |

## Verification
Because the lookup is combinational, any bad stored state shows up at `lookupHit`, `nextPc` and `predTarget` in the same cycle that a fetch reaches the affected index. A valid flag that survives reset, or a tag or target written to the wrong place, therefore appears on the first lookup of that index. A write that lands one cycle early shows up as a changed result in a same-cycle lookup of the index being written. A write that lands one cycle late shows up in the lookup one cycle after the write. An aliasing error is caught by two PCs that share an index but differ in tag.

// File: rtl/btb_pkg.sv
package btb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic writeEntry;  // commit the execute-stage write this cycle
    logic hitSel;      // lookup hit: expose the stored target
    logic redirect;    // final prediction taken: steer fetch to the target
  } btbStrobes_t;

endpackage

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int OFS_W   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   fetchPc,
  input  logic [PC_W-1:0]   wrPc,
  input  logic [PC_W-1:0]   wrTarget,
  input  logic              wrIsJump,
  input  btbStrobes_t       strobes,
  output logic              rdValid,
  output logic [TAG_W-1:0]  rdTag,
  output logic [TAG_W-1:0]  fetchTag,
  output logic              rdIsJump,
  output logic [PC_W-1:0]   nextPc,
  output logic [PC_W-1:0]   predTarget
);

  logic [IDX_W-1:0] fetchIdx;
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] wrTag;
  logic [PC_W-1:0]  pcPlus4;
  logic [PC_W-1:0]  rdTarget;
  logic             unusedWrOfs;

  logic [ENTRIES-1:0] validQ;
  logic [TAG_W-1:0]   tagMem    [ENTRIES];
  logic [PC_W-1:0]    targetMem [ENTRIES];
  logic [ENTRIES-1:0] jumpMem;

  // Address split: byte offset, then index, then tag
  assign fetchIdx    = fetchPc[OFS_W +: IDX_W];
  assign fetchTag    = fetchPc[PC_W-1 -: TAG_W];
  assign wrIdx       = wrPc[OFS_W +: IDX_W];
  assign wrTag       = wrPc[PC_W-1 -: TAG_W];
  assign unusedWrOfs = ^wrPc[OFS_W-1:0];

  // Valid flags: the only state that reset touches
  for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        validQ[e] <= 1'b0;
      else if (strobes.writeEntry && (wrIdx == IDX_W'(e)))
        validQ[e] <= 1'b1;
    end
  end

  // Payload storage, no reset needed
  always_ff @(posedge clk) begin
    if (strobes.writeEntry) begin
      tagMem[wrIdx]    <= wrTag;
      targetMem[wrIdx] <= wrTarget;
      jumpMem[wrIdx]   <= wrIsJump;
    end
  end

  // Combinational read; sees pre-write contents in the write cycle
  assign rdValid  = validQ[fetchIdx];
  assign rdTag    = tagMem[fetchIdx];
  assign rdTarget = targetMem[fetchIdx];
  assign rdIsJump = jumpMem[fetchIdx];

  // Next-PC datapath
  assign pcPlus4    = fetchPc + PC_W'(4);
  assign predTarget = strobes.hitSel   ? rdTarget : pcPlus4;
  assign nextPc     = strobes.redirect ? rdTarget : pcPlus4;

  AST_VALID_ONE_PER_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    $countones(validQ) <= $past($countones(validQ)) + 1) else $error("valid grew by more than one");  // R6

  AST_WRITE_MARKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeEntry |=> validQ[$past(wrIdx)]) else $error("written entry not valid");  // R6

endmodule

// File: rtl/btb_ctrl.sv
module btb_ctrl
  import btb_pkg::*;
#(
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dirTaken,
  input  logic             wrEn,
  input  logic             rdValid,
  input  logic [TAG_W-1:0] rdTag,
  input  logic [TAG_W-1:0] fetchTag,
  input  logic             rdIsJump,
  output btbStrobes_t      strobes,
  output logic             lookupHit,
  output logic             predTaken
);

  logic tagMatch;

  assign tagMatch  = (rdTag == fetchTag);
  assign lookupHit = rdValid && tagMatch;
  // Jump flag and direction bit only matter on a hit
  assign predTaken = lookupHit && (dirTaken || rdIsJump);

  always_comb begin
    strobes            = '0;
    strobes.writeEntry = wrEn;
    strobes.hitSel     = lookupHit;
    strobes.redirect   = predTaken;
  end

  AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> !strobes.redirect) else $error("invalid entry redirected");  // R5

  AST_HIT_JUMP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.hitSel && rdIsJump) |-> strobes.redirect) else $error("jump hit not taken");  // R3

endmodule

// File: rtl/btb_fetch_sel.sv
module btb_fetch_sel
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 64,
  parameter int OFS_W   = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] fetchPc,
  input  logic            dirTaken,
  input  logic            wrEn,
  input  logic [PC_W-1:0] wrPc,
  input  logic [PC_W-1:0] wrTarget,
  input  logic            wrIsJump,
  output logic [PC_W-1:0] nextPc,
  output logic            predTaken,
  output logic [PC_W-1:0] predTarget,
  output logic            lookupHit
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;

  btbStrobes_t      strobes;
  logic             rdValid;
  logic [TAG_W-1:0] rdTag;
  logic [TAG_W-1:0] fetchTag;
  logic             rdIsJump;

  btb_store #(
    .PC_W    (PC_W),
    .ENTRIES (ENTRIES),
    .OFS_W   (OFS_W)
  ) uStore (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .wrPc       (wrPc),
    .wrTarget   (wrTarget),
    .wrIsJump   (wrIsJump),
    .strobes    (strobes),
    .rdValid    (rdValid),
    .rdTag      (rdTag),
    .fetchTag   (fetchTag),
    .rdIsJump   (rdIsJump),
    .nextPc     (nextPc),
    .predTarget (predTarget)
  );

  btb_ctrl #(
    .TAG_W (TAG_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .dirTaken  (dirTaken),
    .wrEn      (wrEn),
    .rdValid   (rdValid),
    .rdTag     (rdTag),
    .fetchTag  (fetchTag),
    .rdIsJump  (rdIsJump),
    .strobes   (strobes),
    .lookupHit (lookupHit),
    .predTaken (predTaken)
  );

  AST_TAKEN_USES_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    predTaken |-> (nextPc == predTarget)) else $error("taken but next PC not target");  // R3

  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !predTaken |-> (nextPc == fetchPc + PC_W'(4))) else $error("not taken but no fall-through");  // R4

  AST_MISS_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !lookupHit |-> (!predTaken && predTarget == fetchPc + PC_W'(4))) else $error("miss redirected");  // R8

endmodule

// File: tb/sim_btb_fetch_sel.sv
module sim_btb_fetch_sel;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        we;
    logic [31:0] wPc;
    logic [31:0] wTgt;
    logic        wJmp;
    logic [31:0] fPc;
    logic        dir;
    logic        eHit;
    logic        eTaken;
    logic [31:0] eNext;
    logic [31:0] eTgt;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 13;
  // A=0x1004 and B=0x2004 share index 1; C=0x1040 is index 16
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1004, 1'b1, 1'b0, 1'b0, 32'h0000_1008, 32'h0000_1008, 4'd5}, // R5 empty
    '{1'b1, 32'h0000_1004, 32'h0000_3000, 1'b0, 32'h0000_1004, 1'b1, 1'b0, 1'b0, 32'h0000_1008, 32'h0000_1008, 4'd7}, // R7 old
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1004, 1'b1, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_3000, 4'd3}, // R3 dir
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1004, 1'b0, 1'b1, 1'b0, 32'h0000_1008, 32'h0000_3000, 4'd4}, // R4
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_2004, 1'b1, 1'b0, 1'b0, 32'h0000_2008, 32'h0000_2008, 4'd5}, // R5 alias
    '{1'b1, 32'h0000_1040, 32'h0000_0100, 1'b1, 32'h0000_1040, 1'b0, 1'b0, 1'b0, 32'h0000_1044, 32'h0000_1044, 4'd7}, // R7
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1040, 1'b0, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0100, 4'd3}, // R3 jump
    '{1'b1, 32'h0000_2004, 32'h0000_4000, 1'b0, 32'h0000_1004, 1'b1, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_3000, 4'd7}, // R7
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1004, 1'b1, 1'b0, 1'b0, 32'h0000_1008, 32'h0000_1008, 4'd6}, // R6 evicted
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_2004, 1'b1, 1'b1, 1'b1, 32'h0000_4000, 32'h0000_4000, 4'd6}, // R6
    '{1'b1, 32'h0000_1040, 32'h0000_0200, 1'b0, 32'h0000_1040, 1'b0, 1'b1, 1'b1, 32'h0000_0100, 32'h0000_0100, 4'd7}, // R7
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'h0000_1040, 1'b0, 1'b1, 1'b0, 32'h0000_1044, 32'h0000_0200, 4'd6}, // R6 refresh
    '{1'b0, 32'h0, 32'h0, 1'b0, 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000, 4'd9}  // R9
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fetchPc = '0;
  logic        dirTaken = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrPc = '0;
  logic [31:0] wrTarget = '0;
  logic        wrIsJump = 1'b0;
  logic [31:0] nextPc;
  logic        predTaken;
  logic [31:0] predTarget;
  logic        lookupHit;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_fetch_sel u0 (
    .clk        (clk),
    .rstN       (rstN),
    .fetchPc    (fetchPc),
    .dirTaken   (dirTaken),
    .wrEn       (wrEn),
    .wrPc       (wrPc),
    .wrTarget   (wrTarget),
    .wrIsJump   (wrIsJump),
    .nextPc     (nextPc),
    .predTaken  (predTaken),
    .predTarget (predTarget),
    .lookupHit  (lookupHit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic lookAll(input string req, input logic eHit, input logic eTaken,
                         input logic [31:0] eNext, input logic [31:0] eTgt);
    chk(lookupHit == eHit, req, "lookupHit", 32'(lookupHit), 32'(eHit));
    chk(predTaken == eTaken, req, "predTaken", 32'(predTaken), 32'(eTaken));
    chk(nextPc == eNext, req, "nextPc", nextPc, eNext);
    chk(predTarget == eTgt, req, "predTarget", predTarget, eTgt);
  endtask

  task automatic drive(input logic we, input logic [31:0] wp, input logic [31:0] wt,
                       input logic wj, input logic [31:0] fp, input logic d);
    @(negedge clk);
    wrEn = we; wrPc = wp; wrTarget = wt; wrIsJump = wj;
    fetchPc = fp; dirTaken = d;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: state out of reset
    repeat (3) @(posedge clk);
    drive(1'b0, '0, '0, 1'b0, 32'h0000_1004, 1'b1);
    rstN = 1'b1;
    #1;
    lookAll("R1", 1'b0, 1'b0, 32'h0000_1008, 32'h0000_1008);

    // Table walk: sample before the edge that commits the row's write
    for (int i = 0; i < NVEC; i++) begin
      drive(TBL[i].we, TBL[i].wPc, TBL[i].wTgt, TBL[i].wJmp, TBL[i].fPc, TBL[i].dir);
      lookAll($sformatf("R%0d row %0d", TBL[i].req, i),
              TBL[i].eHit, TBL[i].eTaken, TBL[i].eNext, TBL[i].eTgt);
    end

    // R2: top index 63 with all-ones tag; jump flag forces taken (R3)
    drive(1'b1, 32'hFFFF_FFFC, 32'h0000_0008, 1'b1, 32'h0000_10FC, 1'b0);
    drive(1'b0, '0, '0, 1'b0, 32'hFFFF_FFFC, 1'b0);
    lookAll("R2", 1'b1, 1'b1, 32'h0000_0008, 32'h0000_0008);
    // R2: same index, different tag misses
    drive(1'b0, '0, '0, 1'b0, 32'h0000_10FC, 1'b1);
    lookAll("R2", 1'b0, 1'b0, 32'h0000_1100, 32'h0000_1100);

    // R1: reset wipes entries that were valid
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    drive(1'b0, '0, '0, 1'b0, 32'h0000_2004, 1'b1);
    lookAll("R1", 1'b0, 1'b0, 32'h0000_2008, 32'h0000_2008);
    drive(1'b0, '0, '0, 1'b0, 32'hFFFF_FFFC, 1'b0);
    lookAll("R1", 1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule